// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Interface Controller

This block moves one byte at a time over a four-wire SPI link, either as the clock-driving master or as a selected slave. Software reaches it through three byte registers on a simple synchronous bus: control, status and data. The clock polarity and phase bits choose among the four SPI clock modes. A received byte raises a receive-full flag, and gated interrupt lines signal a full receive buffer and an empty transmit buffer.

The enable bit, the master bit and the mode-fault enable bit together decide whether the slave-select pin belongs to the SPI or stays general-purpose I/O. A master that owns slave-select treats a low level there as a mode fault. It then latches a fault flag, clears its own enable and releases every pin. A wired-OR option makes each serial output open-drain: it either pulls low or floats.

Top module: `spi_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x28, the status register (address 1) reads 0x08, the data register (address 2) reads 0x00, and both interrupt lines are low.
- R2: Control bits from 7 to 0 are: receive interrupt enable, reserved (always reads 0), master, CPOL, CPHA, wired-OR, enable, transmit interrupt enable. Writing 0xFF reads back 0xBF.
- R3: `ss_owned` is high exactly when enable is 1 and either master is 0 or mode-fault enable is 1.
- R4: As an enabled master, a pending transmit byte is shifted out MSB first on `mosi` over 16 clock edges spaced `HALF_DIV` cycles apart. SCK idles at CPOL. Input data is sampled on the leading edge when CPHA=0 and on the trailing edge when CPHA=1. The byte sampled from `miso` becomes the received byte.
- R5: The transmit-empty flag (status bit 3) resets to 1, clears on a data register write, and sets again when the byte is loaded into the shift register.
- R6: The receive-full flag (status bit 7) sets when a byte completes, with that byte readable at address 2. A data read alone does not clear it. A status read made while it is set, followed by a data read, clears it.
- R7: `irq_rx` equals receive-full AND control bit 7. `irq_tx` equals transmit-empty AND control bit 0.
- R8: With wired-OR set, no serial output is ever driven high. A pin that would be 1 is released and a pin that would be 0 is driven low.
- R9: A master with mode-fault enable at 1 that sees slave-select low sets the mode-fault flag (status bit 4), clears the control enable bit and releases all outputs. With mode-fault enable at 0 it ignores slave-select.
- R10: Mode-fault enable is status bit 0, read/write. Writing status with bit 4 at 1 clears the mode-fault flag.
- R11: As an enabled slave, a falling slave-select loads the transmit byte. The slave then exchanges 8 bits MSB first on the external SCK, using the same edge rules as R4. `miso` is driven only while slave-select is low, and the received byte sets receive-full.
- R12: While enable is 0, SCK and slave-select activity has no effect on the flags, no pin is driven and `ss_owned` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (for read side effects) |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out value |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out line in (slave) |
| mosi_o | output | 1 | Master-out value |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in line in (master) |
| miso_o | output | 1 | Master-in value (slave) |
| miso_oe | output | 1 | Master-in output enable |
| ss_n_i | input | 1 | Slave-select pin, active low |
| ss_owned | output | 1 | Slave-select is an input to the SPI |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_tx | output | 1 | Transmit-empty interrupt request |

## Verification
Master transfers are swept over all four clock modes with bytes of differing bit patterns, against a behavioural slave on the bus lines. A wrong sampling edge, a wrong bit order or a spurious first shift under CPHA=1 each corrupt a different bit of the captured data. Slave transfers mirror this from a behavioural master, so the edge rules are also checked when the clock comes from outside. All eight combinations of enable, master and mode-fault enable are walked to separate slave-select ownership from mode-fault action. A wired-OR pass with pull-ups shows that the open-drain lines still carry the same data.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned EDGES  = 2 * BYTE_W;
  localparam int unsigned EDGE_W = $clog2(EDGES);

  localparam int unsigned C_RXIE = 7;
  localparam int unsigned C_RSVD = 6;
  localparam int unsigned C_MSTR = 5;
  localparam int unsigned C_CPOL = 4;
  localparam int unsigned C_CPHA = 3;
  localparam int unsigned C_WOM  = 2;
  localparam int unsigned C_EN   = 1;
  localparam int unsigned C_TXIE = 0;
  localparam logic [BYTE_W-1:0] CTRL_RST = 8'h28;

  localparam int unsigned S_RXF  = 7;
  localparam int unsigned S_MODF = 4;
  localparam int unsigned S_TXE  = 3;
  localparam int unsigned S_MFEN = 0;

  typedef enum logic [1:0] {A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2} spi_addr_e;

  typedef struct packed {
    logic o;
    logic oe;
  } pin_drv_t;

  // slave-select belongs to the SPI for an enabled slave or a fault-guarded master
  function automatic logic ss_is_input(logic en, logic mstr, logic mfen);
    return en & (~mstr | mfen);
  endfunction

  // data is captured on the leading edge in phase 0, on the trailing edge in phase 1
  function automatic logic is_sample_edge(logic leading, logic cpha);
    return leading ^ cpha;
  endfunction

  // push-pull or open-drain drive of one serial pin
  function automatic pin_drv_t pin_drive(logic val, logic act, logic wom);
    pin_drv_t d;
    if (!act) begin
      d.o  = 1'b0;
      d.oe = 1'b0;
    end else if (wom) begin
      d.o  = 1'b0;
      d.oe = ~val;
    end else begin
      d.o  = val;
      d.oe = 1'b1;
    end
    return d;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES <= 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
      end
    end else begin : g_chain
      localparam int unsigned CW = STAGES * WIDTH;
      logic [CW-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[CW-WIDTH-1:0], d};
      end
      assign q = chain[CW-1 -: WIDTH];
    end
  endgenerate
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              load_p,
  input  logic              done_p,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              modf_evt,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              mfen,
  output logic [BYTE_W-1:0] tx_buf,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              modf
);
  localparam logic [BYTE_W-1:0] RSVD_MASK = BYTE_W'(1) << C_RSVD;

  logic wr_ctrl, wr_stat, wr_data, rd_stat, rd_data;
  logic [BYTE_W-1:0] ctrl_d, rx_buf, stat_v;
  logic armed;

  assign wr_ctrl = bus_sel & bus_wr & (bus_addr == A_CTRL);
  assign wr_stat = bus_sel & bus_wr & (bus_addr == A_STAT);
  assign wr_data = bus_sel & bus_wr & (bus_addr == A_DATA);
  assign rd_stat = bus_sel & bus_rd & (bus_addr == A_STAT);
  assign rd_data = bus_sel & bus_rd & (bus_addr == A_DATA);

  always_comb begin
    ctrl_d = wr_ctrl ? (bus_wdata & ~RSVD_MASK) : ctrl_q;
    if (modf_evt) ctrl_d[C_EN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      mfen   <= 1'b0;
      modf   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_stat) mfen <= bus_wdata[S_MFEN];
      if (modf_evt) modf <= 1'b1;
      else if (wr_stat && bus_wdata[S_MODF]) modf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf   <= '0;
      tx_empty <= 1'b1;
    end else if (wr_data) begin
      tx_buf   <= bus_wdata;
      tx_empty <= 1'b0;
    end else if (load_p) begin
      tx_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
      armed   <= 1'b0;
    end else if (done_p) begin
      rx_buf  <= rx_byte;
      rx_full <= 1'b1;
      armed   <= 1'b0;
    end else if (rd_data && armed) begin
      rx_full <= 1'b0;
      armed   <= 1'b0;
    end else if (rd_stat && rx_full) begin
      armed   <= 1'b1;
    end
  end

  always_comb begin
    stat_v         = '0;
    stat_v[S_RXF]  = rx_full;
    stat_v[S_MODF] = modf;
    stat_v[S_TXE]  = tx_empty;
    stat_v[S_MFEN] = mfen;
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = stat_v;
      A_DATA:  bus_rdata = rx_buf;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = $clog2(HALF_DIV + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run & (cnt == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              mstr,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [BYTE_W-1:0] tx_buf,
  input  logic              tx_pending,
  input  logic              tick,
  input  logic              sck_s,
  input  logic              ss_s,
  input  logic              miso_i,
  input  logic              mosi_i,
  input  logic              abort,
  output logic              busy,
  output logic              run,
  output logic              load_p,
  output logic              done_p,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sck_lvl,
  output logic              dout
);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  logic [EDGE_W-1:0] ecnt;
  logic [BYTE_W-1:0] tx_sr, rx_sr;
  logic phase, sck_prev, ss_prev;
  logic slave_start, mst_start, start, kill, edge_ev, leading, samp, shft, last, din;

  assign slave_start = en & ~mstr & ss_prev & ~ss_s;
  assign mst_start   = en & mstr & ~busy & tx_pending & ~abort;
  assign start       = mst_start | slave_start;
  assign kill        = abort | (busy & (~en | (~mstr & ss_s)));
  assign edge_ev     = busy & (mstr ? tick : (sck_s ^ sck_prev));
  assign leading     = ~ecnt[0];
  assign samp        = is_sample_edge(leading, cpha);
  assign shft        = ~samp & ~(cpha & (ecnt == '0));
  assign last        = (ecnt == LAST_EDGE);
  assign din         = mstr ? miso_i : mosi_i;
  assign rx_byte     = samp ? {rx_sr[BYTE_W-2:0], din} : rx_sr;

  assign load_p  = start & ~kill;
  assign done_p  = edge_ev & last & ~kill;
  assign run     = busy & mstr;
  assign sck_lvl = cpol ^ phase;
  assign dout    = tx_sr[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      ss_prev  <= 1'b1;
    end else begin
      sck_prev <= sck_s;
      ss_prev  <= ss_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ecnt  <= '0;
      tx_sr <= '0;
      rx_sr <= '0;
      phase <= 1'b0;
    end else if (kill) begin
      busy  <= 1'b0;
      phase <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      ecnt  <= '0;
      tx_sr <= tx_buf;
      phase <= 1'b0;
    end else if (edge_ev) begin
      ecnt  <= ecnt + EDGE_W'(1);
      rx_sr <= rx_byte;
      phase <= ~phase;
      if (shft) tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        sck_i,
  output logic        sck_o,
  output logic        sck_oe,
  input  logic        mosi_i,
  output logic        mosi_o,
  output logic        mosi_oe,
  input  logic        miso_i,
  output logic        miso_o,
  output logic        miso_oe,
  input  logic        ss_n_i,
  output logic        ss_owned,
  output logic        irq_rx,
  output logic        irq_tx
);
  logic [BYTE_W-1:0] ctrl_q, tx_buf, rx_byte;
  logic mfen, tx_empty, rx_full, modf;
  logic ctrl_en, ctrl_mstr, ctrl_cpol, ctrl_cpha, ctrl_wom;
  logic [1:0] syn_q;
  logic ss_s, sck_s, modf_evt, master_act, slave_sel;
  logic busy, run, tick, load_p, done_p, sck_lvl, dout;
  pin_drv_t sck_d, mosi_d, miso_d;

  assign ctrl_en   = ctrl_q[C_EN];
  assign ctrl_mstr = ctrl_q[C_MSTR];
  assign ctrl_cpol = ctrl_q[C_CPOL];
  assign ctrl_cpha = ctrl_q[C_CPHA];
  assign ctrl_wom  = ctrl_q[C_WOM];

  spi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({ss_n_i, sck_i}), .q(syn_q)
  );
  assign ss_s  = syn_q[1];
  assign sck_s = syn_q[0];

  assign ss_owned   = ss_is_input(ctrl_en, ctrl_mstr, mfen);
  assign modf_evt   = ss_owned & ctrl_mstr & ~ss_s;
  assign master_act = ctrl_en & ctrl_mstr;
  assign slave_sel  = ctrl_en & ~ctrl_mstr & ~ss_s;

  spi_regs i_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .load_p(load_p), .done_p(done_p), .rx_byte(rx_byte), .modf_evt(modf_evt),
    .ctrl_q(ctrl_q), .mfen(mfen), .tx_buf(tx_buf), .tx_empty(tx_empty),
    .rx_full(rx_full), .modf(modf)
  );

  spi_clkgen #(.HALF_DIV(HALF_DIV)) i_clkgen (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  spi_engine i_engine (
    .clk(clk), .rst_n(rst_n),
    .en(ctrl_en), .mstr(ctrl_mstr), .cpol(ctrl_cpol), .cpha(ctrl_cpha),
    .tx_buf(tx_buf), .tx_pending(~tx_empty), .tick(tick),
    .sck_s(sck_s), .ss_s(ss_s), .miso_i(miso_i), .mosi_i(mosi_i), .abort(modf_evt),
    .busy(busy), .run(run), .load_p(load_p), .done_p(done_p), .rx_byte(rx_byte),
    .sck_lvl(sck_lvl), .dout(dout)
  );

  assign sck_d  = pin_drive(sck_lvl, master_act, ctrl_wom);
  assign mosi_d = pin_drive(dout, master_act, ctrl_wom);
  assign miso_d = pin_drive(dout, slave_sel, ctrl_wom);

  assign sck_o   = sck_d.o;
  assign sck_oe  = sck_d.oe;
  assign mosi_o  = mosi_d.o;
  assign mosi_oe = mosi_d.oe;
  assign miso_o  = miso_d.o;
  assign miso_oe = miso_d.oe;

  assign irq_rx = rx_full & ctrl_q[C_RXIE];
  assign irq_tx = tx_empty & ctrl_q[C_TXIE];
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       en,
  input logic       mstr,
  input logic       cpol,
  input logic       wom,
  input logic       busy,
  input logic       modf,
  input logic       tx_empty,
  input logic       rx_full,
  input logic       load_p,
  input logic       done_p,
  input logic       sck_o,
  input logic       sck_oe,
  input logic       mosi_o,
  input logic       mosi_oe,
  input logic       miso_o,
  input logic       miso_oe,
  input logic       ss_owned
);
  logic wr_data;
  assign wr_data = bus_sel & bus_wr & (bus_addr == 2'd2);

  p_owned_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ss_owned |-> en);

  p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mstr && !busy && !wom) |-> (sck_oe && sck_o == cpol));

  p_load_sets_txe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_p && !wr_data) |=> tx_empty);

  p_done_sets_rxf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_p |=> rx_full);

  p_wom_no_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wom |-> (!(sck_oe && sck_o) && !(mosi_oe && mosi_o) && !(miso_oe && miso_o)));

  p_modf_drops_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> !en);

  p_slave_no_master_pins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mstr |-> (!sck_oe && !mosi_oe));

  p_idle_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!sck_oe && !mosi_oe && !miso_oe));
endmodule

bind spi_ctrl spi_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .en(ctrl_en), .mstr(ctrl_mstr), .cpol(ctrl_cpol), .wom(ctrl_wom), .busy(busy),
  .modf(modf), .tx_empty(tx_empty), .rx_full(rx_full), .load_p(load_p), .done_p(done_p),
  .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
  .miso_o(miso_o), .miso_oe(miso_oe), .ss_owned(ss_owned)
);

// File: tb/test_spi_ctrl.sv
module test_spi_ctrl;
  localparam int CLK_PER = 10;
  localparam int HALF = 2;
  localparam int SH = 6;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic sck_i = 0, mosi_i = 0, ss_n_i = 1;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, miso_i;
  logic ss_owned, irq_rx, irq_tx;

  int checks = 0, fails = 0, cyc = 0;
  logic cfg_cpha = 0, m_on = 0;
  logic [7:0] m_sh = 0, m_cap = 0;
  int m_edges = 0, m_last = 0, m_bad = 0;
  logic sck_line, mosi_line, miso_line;

  spi_ctrl #(.HALF_DIV(HALF)) i_spi_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_n_i(ss_n_i), .ss_owned(ss_owned), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // pulled-up bus lines
  assign sck_line  = sck_oe  ? sck_o  : 1'b1;
  assign mosi_line = mosi_oe ? mosi_o : 1'b1;
  assign miso_line = miso_oe ? miso_o : 1'b1;
  assign miso_i    = m_sh[7];

  // behavioural slave for master-mode transfers
  always @(sck_line) begin
    if (m_on) begin
      if (((m_edges % 2) == 0) != cfg_cpha) m_cap = {m_cap[6:0], mosi_line};
      else if (!(cfg_cpha && m_edges == 0)) m_sh = {m_sh[6:0], 1'b0};
      if (m_edges > 0 && (cyc - m_last) != HALF) m_bad++;
      m_last = cyc;
      m_edges++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic master_xfer(input logic cpol, input logic cpha, input logic wom,
                             input logic [7:0] tb, input logic [7:0] sb);
    logic [7:0] v;
    wr(2'd0, {1'b1, 1'b0, 1'b1, cpol, cpha, wom, 1'b1, 1'b1});
    idle(3);
    chk("R4 idle sck", sck_line, cpol);
    cfg_cpha = cpha; m_sh = sb; m_cap = 0; m_edges = 0; m_bad = 0; m_on = 1;
    wr(2'd2, tb);
    chk("R5 txe cleared by write", irq_tx, 0);
    idle(1);
    chk("R5 txe set on load", irq_tx, 1);
    idle(16 * HALF + 6);
    m_on = 0;
    chk("R4 edge count", m_edges, 16);
    chk("R4 half period", m_bad, 0);
    chk("R4 mosi byte", m_cap, tb);
    chk("R7 irq_rx", irq_rx, 1);
    rd(2'd2, v); chk("R6 rx byte", v, sb);
    rd(2'd1, v); chk("R6 data read alone keeps rxf", v[7], 1);
    rd(2'd2, v);
    rd(2'd1, v); chk("R6 status then data clears rxf", v[7], 0);
  endtask

  task automatic slave_xfer(input logic cpol, input logic cpha,
                            input logic [7:0] mb, input logic [7:0] sb);
    logic [7:0] v, cap;
    cap = 0;
    sck_i = cpol; ss_n_i = 1;
    wr(2'd0, {1'b1, 1'b0, 1'b0, cpol, cpha, 1'b0, 1'b1, 1'b0});
    wr(2'd2, sb);
    idle(4);
    chk("R11 miso released while deselected", miso_oe, 0);
    ss_n_i = 0;
    if (!cpha) mosi_i = mb[7];
    idle(8);
    for (int i = 0; i < 8; i++) begin
      idle(SH);
      sck_i = ~sck_i;
      if (!cpha) cap = {cap[6:0], miso_line};
      else mosi_i = mb[7-i];
      idle(SH);
      sck_i = ~sck_i;
      if (cpha) cap = {cap[6:0], miso_line};
      else if (i < 7) mosi_i = mb[6-i];
    end
    idle(8);
    chk("R11 miso byte", cap, sb);
    ss_n_i = 1;
    idle(6);
    chk("R11 rx irq", irq_rx, 1);
    rd(2'd2, v); chk("R11 rx byte", v, mb);
    rd(2'd1, v);
    rd(2'd2, v);
  endtask

  initial begin
    #(CLK_PER * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl reset", v, 8'h28);
    rd(2'd1, v); chk("R1 status reset", v, 8'h08);
    rd(2'd2, v); chk("R1 data reset", v, 8'h00);
    chk("R1 irq_rx", irq_rx, 0);
    chk("R1 irq_tx", irq_tx, 0);

    // R2 layout and reserved bit, R7 transmit interrupt gating
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk("R2 reserved bit", v, 8'hBF);
    chk("R7 irq_tx with enable", irq_tx, 1);
    chk("R7 irq_rx no data", irq_rx, 0);
    wr(2'd0, 8'h7E);
    chk("R7 irq_tx gated", irq_tx, 0);
    wr(2'd0, 8'h00);

    // R3 slave-select ownership over every combination
    for (int c = 0; c < 8; c++) begin
      logic e, m, f, exp;
      e = c[2]; m = c[1]; f = c[0];
      case ({e, m, f})
        3'b100, 3'b101, 3'b111: exp = 1;
        default:                exp = 0;
      endcase
      wr(2'd1, {7'd0, f});
      wr(2'd0, {2'b00, m, 3'b000, e, 1'b0});
      chk("R3 ss_owned", ss_owned, exp);
    end
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);

    // R4 R5 R6 R7 master sweep over all clock modes
    for (int md = 0; md < 4; md++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] tb, sb;
        tb = 8'((8'h1D * (k + 1) + md * 8'h40));
        sb = {tb[0], tb[7:1]} ^ 8'hC3;
        master_xfer(md[1], md[0], 1'b0, tb, sb);
      end
    end

    // R8 wired-OR transfers through pull-ups
    master_xfer(1'b0, 1'b0, 1'b1, 8'h96, 8'h5A);
    master_xfer(1'b1, 1'b1, 1'b1, 8'h4B, 8'hE1);
    chk("R8 sck never driven high", sck_oe && sck_o, 0);

    // R9 mode fault
    wr(2'd0, 8'h22);
    ss_n_i = 0;
    idle(6);
    rd(2'd0, v); chk("R9 no fault without mfen", v, 8'h22);
    rd(2'd1, v); chk("R9 modf clear without mfen", v[4], 0);
    wr(2'd1, 8'h01);
    idle(6);
    rd(2'd1, v); chk("R9 modf set", v, 8'h19);
    rd(2'd0, v); chk("R9 enable cleared", v, 8'h20);
    chk("R9 outputs released", {sck_oe, mosi_oe, miso_oe}, 0);
    ss_n_i = 1;
    idle(4);
    wr(2'd1, 8'h11);
    rd(2'd1, v); chk("R10 modf cleared by write", v, 8'h09);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R10 mfen written", v[0], 0);

    // R11 slave sweep
    for (int md = 0; md < 4; md++) begin
      for (int k = 0; k < 2; k++) begin
        logic [7:0] mb, sb;
        mb = 8'(8'h6C + md * 8'h11 + k * 8'h83);
        sb = ~{mb[3:0], mb[7:4]};
        slave_xfer(md[1], md[0], mb, sb);
      end
    end

    // R12 disabled block ignores pins
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h01);
    ss_n_i = 0;
    for (int i = 0; i < 20; i++) begin
      idle(3);
      sck_i = ~sck_i;
    end
    ss_n_i = 1;
    idle(4);
    rd(2'd1, v); chk("R12 flags untouched", v, 8'h09);
    chk("R12 pins released", {sck_oe, mosi_oe, miso_oe}, 0);
    chk("R12 ss not owned", ss_owned, 0);
    wr(2'd0, 8'h28);
    chk("R12 ss not owned as disabled master", ss_owned, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule